// File: doc/BRIEF.md
# Dual-bit start/stop flit detector

This block sits behind a pair of receive comparators that deliver two bits per receive clock: an even bit (earlier in time) and an odd bit (later in time). While no frame is open it hunts for the 8-bit start pattern. Once the start pattern is found it opens the frame and hunts for the 8-bit stop pattern, which closes the frame again. Matching runs two bits per cycle through a small check-state machine. It finds a pattern both when the pattern's first bit lands on an even position and when the whole stream is offset by one bit, so that the pattern straddles pair boundaries.

On a start match the block emits a one-cycle start pulse, raises the active output that enables the downstream deserializer and decoders, and records which alignment matched on the shift output. The upstream alignment stage uses that flag to re-pair bits for the rest of the frame. During the frame only the recorded alignment is searched for the stop pattern. A configuration enable gates the whole detector. When the enable is low, all matching progress, the frame state and the alignment flag are dropped.

Top module: `flit_detector`

## Requirements
- R1: While rst_ni is low, start_o, stop_o, active_o and shift_o are all 0.
- R2: Each cycle the pair {even_i, odd_i} is consumed, even first in time; the start pattern is 11011111, first bit first. With active_o low, the aligned sequence of pairs 11, 01, 11, 11 makes start_o 1 for exactly the one cycle after the edge that samples the fourth pair, with active_o rising and shift_o at 0 on that same edge; no pulse appears after the third pair.
- R3: With active_o low, the start pattern offset by one bit (a pair whose odd bit is 1, then 10, 11, 11, then a pair whose even bit is 1) gives the start pulse after the fifth pair, with shift_o set to 1.
- R4: When a pair breaks a partial match, the detector returns to its start state and evaluates that same pair as a possible first pair; so 11, 11, 01, 11, 11 ends in a start detection.
- R5: With active_o high, the stop pattern 10111111 in the recorded alignment (pairs 10, 11, 11, 11 when shift_o is 0; pairs x1, 01, 11, 11, 1x when shift_o is 1) makes stop_o 1 for one cycle and drops active_o on the same edge.
- R6: With active_o high, the start pattern produces no start_o, and a stop pattern in the alignment other than the recorded one produces no stop_o and leaves active_o high.
- R7: With active_o low, the stop pattern produces no stop_o and leaves active_o low.
- R8: shift_o changes only when a start is detected (or the detector is disabled or reset); it holds through the frame and after the stop pulse.
- R9: While det_en_i is low, active_o, shift_o, start_o and stop_o go to 0 on the next edge, start patterns are not detected, and a partial match in progress is discarded.
- R10: start_o and stop_o are never 1 in the same cycle, and neither stays 1 for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock, one bit pair per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_en_i | input | 1 | Detector enable from configuration |
| even_i | input | 1 | Earlier bit of the current pair |
| odd_i | input | 1 | Later bit of the current pair |
| start_o | output | 1 | One-cycle pulse on start pattern match |
| stop_o | output | 1 | One-cycle pulse on stop pattern match |
| shift_o | output | 1 | 1 when the frame's pattern arrived offset by one bit |
| active_o | output | 1 | Frame open; enables deserializer and decoders |

## Verification
The hardest situation to reach is the failed partial match that hides the real start of a pattern. Here a pair that breaks one candidate must at once begin a new match, and both alignments may be alive for a while before one dies. The bench drives this directly. It sends a doubled leading pair ahead of an aligned start. It sends a stop pattern in the wrong alignment during a shifted frame, where the repeated 11 pairs keep restarting the shifted candidate without ever closing the frame. It also drops the enable in the middle of a partial match, which shows that the half-matched prefix does not carry over.

// File: rtl/flit_det_pkg.sv
package flit_det_pkg;

  // {even, odd}; even bit is earlier on the wire
  typedef logic [1:0] pair_t;

  // live match candidates: aligned and one-bit-offset
  typedef struct packed {
    logic ca;
    logic cs;
  } cand_t;

  localparam cand_t CAND_NONE = '{ca: 1'b0, cs: 1'b0};
  localparam cand_t CAND_BOTH = '{ca: 1'b1, cs: 1'b1};

endpackage

// File: rtl/flit_pair_step.sv
module flit_pair_step
  import flit_det_pkg::*;
#(
  parameter int unsigned PAT_W = 8,
  parameter logic [PAT_W-1:0] PATTERN = 8'b11011111,
  localparam int unsigned NP = PAT_W / 2,
  localparam int unsigned DW = $clog2(NP + 2)
) (
  input  logic [DW-1:0] depth_i,
  input  cand_t         cand_i,
  input  cand_t         allow_i,
  input  pair_t         pair_i,
  output logic [DW-1:0] depth_o,
  output cand_t         cand_o,
  output logic          hit_o,
  output logic          hit_shift_o
);

  localparam int unsigned W  = PAT_W + 2;
  localparam int unsigned NT = 2 ** DW;

  // aligned: pattern starts on an even slot; offset: starts on an odd slot
  localparam logic [W-1:0] AL_VAL = {PATTERN, 2'b00};
  localparam logic [W-1:0] AL_MSK = {{PAT_W{1'b1}}, 2'b00};
  localparam logic [W-1:0] SH_VAL = {1'b0, PATTERN, 1'b0};
  localparam logic [W-1:0] SH_MSK = {1'b0, {PAT_W{1'b1}}, 1'b0};

  pair_t al_val [NT];
  pair_t al_msk [NT];
  pair_t sh_val [NT];
  pair_t sh_msk [NT];

  for (genvar k = 0; k < NT; k++) begin : g_tgt
    localparam logic [W-1:0] AV = AL_VAL << (2 * k);
    localparam logic [W-1:0] AM = AL_MSK << (2 * k);
    localparam logic [W-1:0] SV = SH_VAL << (2 * k);
    localparam logic [W-1:0] SM = SH_MSK << (2 * k);
    assign al_val[k] = AV[W-1:W-2];
    assign al_msk[k] = AM[W-1:W-2];
    assign sh_val[k] = SV[W-1:W-2];
    assign sh_msk[k] = SM[W-1:W-2];
  end

  function automatic cand_t eval_pair(input logic [DW-1:0] k, input cand_t c,
                                      input pair_t p);
    cand_t r;
    r.ca = c.ca && (al_msk[k] == 2'b11) && (p == al_val[k]);
    r.cs = c.cs && (sh_msk[k] != 2'b00) &&
           (((p ^ sh_val[k]) & sh_msk[k]) == 2'b00);
    return r;
  endfunction

  cand_t first_c;
  cand_t cont_c;
  cand_t step_c;
  logic  hit_al;
  logic  hit_sh;

  always_comb begin
    first_c = eval_pair('0, allow_i, pair_i);
    cont_c  = eval_pair(depth_i, cand_i, pair_i);
    step_c  = (depth_i == '0) ? first_c : cont_c;
    hit_al  = step_c.ca && (depth_i == DW'(NP - 1));
    hit_sh  = step_c.cs && (depth_i == DW'(NP));

    hit_o       = 1'b0;
    hit_shift_o = 1'b0;
    depth_o     = '0;
    cand_o      = CAND_NONE;
    if (hit_al) begin
      hit_o = 1'b1;
    end else if (hit_sh) begin
      hit_o       = 1'b1;
      hit_shift_o = 1'b1;
    end else if (step_c.ca || step_c.cs) begin
      depth_o = depth_i + 1'b1;
      cand_o  = step_c;
    end else if (depth_i != '0 && (first_c.ca || first_c.cs)) begin
      // broken partial match: current pair may open a new one
      depth_o = DW'(1);
      cand_o  = first_c;
    end
  end

endmodule

// File: rtl/flit_frame_ctrl.sv
module flit_frame_ctrl
  import flit_det_pkg::*;
#(
  parameter int unsigned PAT_W = 8,
  localparam int unsigned NP = PAT_W / 2,
  localparam int unsigned DW = $clog2(NP + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_hit_i,
  input  logic          start_shift_i,
  input  logic          stop_hit_i,
  input  logic          stop_shift_i,
  input  logic [DW-1:0] depth_nxt_i,
  input  cand_t         cand_nxt_i,
  output logic [DW-1:0] depth_o,
  output cand_t         cand_o,
  output logic          active_o,
  output logic          shift_o,
  output logic          start_o,
  output logic          stop_o
);

  logic take_start;
  logic take_stop;

  assign take_start = !active_o && start_hit_i;
  assign take_stop  = active_o && stop_hit_i && (stop_shift_i == shift_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_o  <= '0;
      cand_o   <= CAND_NONE;
      active_o <= 1'b0;
      shift_o  <= 1'b0;
      start_o  <= 1'b0;
      stop_o   <= 1'b0;
    end else if (!en_i) begin
      depth_o  <= '0;
      cand_o   <= CAND_NONE;
      active_o <= 1'b0;
      shift_o  <= 1'b0;
      start_o  <= 1'b0;
      stop_o   <= 1'b0;
    end else begin
      start_o <= take_start;
      stop_o  <= take_stop;
      if (take_start) begin
        active_o <= 1'b1;
        shift_o  <= start_shift_i;
        depth_o  <= '0;
        cand_o   <= CAND_NONE;
      end else if (take_stop) begin
        active_o <= 1'b0;
        depth_o  <= '0;
        cand_o   <= CAND_NONE;
      end else begin
        depth_o <= depth_nxt_i;
        cand_o  <= cand_nxt_i;
      end
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DW'(NP)); // R3
  AST_LAST_CHECK_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o == DW'(NP)) |-> (cand_o.cs && !cand_o.ca)); // R3
  AST_EN_LOW_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!active_o && !shift_o && !start_o && !stop_o && depth_o == '0)); // R9
  AST_SHIFT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_o && $past(en_i)) |-> $stable(shift_o)); // R8
  AST_START_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (active_o && !$past(active_o))); // R2
  AST_STOP_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> (!active_o && $past(active_o))); // R5

endmodule

// File: rtl/flit_detector.sv
module flit_detector
  import flit_det_pkg::*;
#(
  parameter int unsigned PAT_W = 8,
  parameter logic [PAT_W-1:0] START_PAT = 8'b11011111,
  parameter logic [PAT_W-1:0] STOP_PAT  = 8'b10111111
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_en_i,
  input  logic even_i,
  input  logic odd_i,
  output logic start_o,
  output logic stop_o,
  output logic shift_o,
  output logic active_o
);

  localparam int unsigned NP = PAT_W / 2;
  localparam int unsigned DW = $clog2(NP + 2);

  pair_t         pair;
  logic [DW-1:0] depth_q;
  cand_t         cand_q;
  cand_t         allow   [2];
  logic [DW-1:0] s_depth [2];
  cand_t         s_cand  [2];
  logic          s_hit   [2];
  logic          s_shift [2];
  logic [DW-1:0] depth_nxt;
  cand_t         cand_nxt;

  assign pair = {even_i, odd_i};

  // g=0 hunts start (either alignment), g=1 hunts stop (latched alignment)
  for (genvar g = 0; g < 2; g++) begin : g_hunt
    localparam logic [PAT_W-1:0] PAT = (g == 0) ? START_PAT : STOP_PAT;
    if (g == 0) begin : g_any
      assign allow[g] = CAND_BOTH;
    end else begin : g_latched
      assign allow[g] = '{ca: !shift_o, cs: shift_o};
    end
    flit_pair_step #(
      .PAT_W  (PAT_W),
      .PATTERN(PAT)
    ) u_step (
      .depth_i    (depth_q),
      .cand_i     (cand_q),
      .allow_i    (allow[g]),
      .pair_i     (pair),
      .depth_o    (s_depth[g]),
      .cand_o     (s_cand[g]),
      .hit_o      (s_hit[g]),
      .hit_shift_o(s_shift[g])
    );
  end

  assign depth_nxt = active_o ? s_depth[1] : s_depth[0];
  assign cand_nxt  = active_o ? s_cand[1]  : s_cand[0];

  flit_frame_ctrl #(
    .PAT_W(PAT_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (det_en_i),
    .start_hit_i  (s_hit[0]),
    .start_shift_i(s_shift[0]),
    .stop_hit_i   (s_hit[1]),
    .stop_shift_i (s_shift[1]),
    .depth_nxt_i  (depth_nxt),
    .cand_nxt_i   (cand_nxt),
    .depth_o      (depth_q),
    .cand_o       (cand_q),
    .active_o     (active_o),
    .shift_o      (shift_o),
    .start_o      (start_o),
    .stop_o       (stop_o)
  );

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o)); // R10
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R10
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o); // R10
  AST_NO_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(active_o) |-> !stop_o); // R7

endmodule

// File: tb/flit_detector_test.sv
module flit_detector_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic even = 1'b0;
  logic odd = 1'b0;
  logic start_s, stop_s, shift_s, active_s;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flit_detector uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .det_en_i(en),
    .even_i  (even),
    .odd_i   (odd),
    .start_o (start_s),
    .stop_o  (stop_s),
    .shift_o (shift_s),
    .active_o(active_s)
  );

  task automatic check(input string tag, input logic st, input logic sp,
                       input logic ac, input logic sh);
    n_chk++;
    if ({start_s, stop_s, active_s, shift_s} !== {st, sp, ac, sh}) begin
      n_bad++;
      $display("FAIL %s: start/stop/active/shift = %b%b%b%b, expected %b%b%b%b",
               tag, start_s, stop_s, active_s, shift_s, st, sp, ac, sh);
    end
  endtask

  // drive a pair mid-low phase; return after the sampling edge has settled
  task automatic put(input logic e, input logic o);
    @(negedge clk);
    even = e;
    odd  = o;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset state", 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    put(0, 0);
    check("R1 after release", 0, 0, 0, 0);
  endtask

  task automatic t_aligned_frame;
    put(0, 0);
    put(1, 1); put(0, 1); put(1, 1);
    check("R2 no pulse after third pair", 0, 0, 0, 0);
    put(1, 1);
    check("R2 aligned start", 1, 0, 1, 0);
    put(0, 0);
    check("R10 start pulse one cycle", 0, 0, 1, 0);
    put(1, 1); put(0, 1); put(1, 1); put(1, 1);
    check("R6 start pattern inside frame", 0, 0, 1, 0);
    put(1, 0); put(1, 1); put(1, 1);
    check("R5 no early stop", 0, 0, 1, 0);
    put(1, 1);
    check("R5 aligned stop", 0, 1, 0, 0);
    put(0, 0);
    check("R10 stop pulse one cycle", 0, 0, 0, 0);
  endtask

  task automatic t_shifted_frame;
    put(0, 0);
    put(0, 1); put(1, 0); put(1, 1); put(1, 1);
    check("R3 no pulse after fourth offset pair", 0, 0, 0, 0);
    put(1, 0);
    check("R3 offset start", 1, 0, 1, 1);
    put(0, 0);
    check("R8 shift held in frame", 0, 0, 1, 1);
    put(1, 0); put(1, 1); put(1, 1); put(1, 1);
    check("R6 wrong-alignment stop ignored", 0, 0, 1, 1);
    put(0, 0);
    put(0, 1); put(0, 1); put(1, 1); put(1, 1);
    check("R5 no early offset stop", 0, 0, 1, 1);
    put(1, 0);
    check("R5 offset stop", 0, 1, 0, 1);
    put(0, 0);
    check("R8 shift kept after stop", 0, 0, 0, 1);
  endtask

  task automatic t_restart;
    put(0, 0);
    put(1, 1); put(1, 1); put(0, 1); put(1, 1);
    check("R4 no pulse before completion", 0, 0, 0, 1);
    put(1, 1);
    check("R4 start after broken prefix", 1, 0, 1, 0);
    put(1, 0); put(1, 1); put(1, 1); put(1, 1);
    check("R5 close restart frame", 0, 1, 0, 0);
    put(0, 0);
  endtask

  task automatic t_idle_stop;
    put(1, 0); put(1, 1); put(1, 1); put(1, 1);
    check("R7 aligned stop while idle", 0, 0, 0, 0);
    put(0, 1); put(0, 1); put(1, 1); put(1, 1); put(1, 0);
    check("R7 offset stop while idle", 0, 0, 0, 0);
    put(0, 0); put(0, 0);
  endtask

  task automatic t_enable;
    put(1, 1); put(0, 1); put(1, 1);
    en = 1'b0;
    put(1, 1);
    check("R9 held while disabled", 0, 0, 0, 0);
    en = 1'b1;
    put(1, 1);
    check("R9 partial match discarded", 0, 0, 0, 0);
    put(0, 1); put(1, 1); put(1, 1);
    check("R9 matching resumes", 1, 0, 1, 0);
    en = 1'b0;
    put(0, 0);
    check("R9 disable closes frame", 0, 0, 0, 0);
    en = 1'b1;
    put(0, 1); put(1, 0); put(1, 1); put(1, 1); put(1, 0);
    check("R3 offset start before disable", 1, 0, 1, 1);
    en = 1'b0;
    put(0, 0);
    check("R9 disable clears shift", 0, 0, 0, 0);
    put(1, 1); put(0, 1); put(1, 1); put(1, 1);
    check("R9 start pattern while disabled", 0, 0, 0, 0);
    put(0, 0);
    check("R9 still idle", 0, 0, 0, 0);
    en = 1'b1;
  endtask

  initial begin
    t_reset();
    t_aligned_frame();
    t_shifted_frame();
    t_restart();
    t_idle_stop();
    t_enable();
    finish_run();
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung, expected done");
    finish_run();
  end

endmodule